// File: doc/BRIEF.md
# Ethernet Receive Error Statistics Counters

This block keeps three 32-bit statistics counters for an Ethernet receiver: frames with a bad CRC, frames with an alignment error (dribbling bits), and frames dropped for lack of buffers or for overrun. The receiver gives it one status strobe for each completed frame. The strobe carries five flags: address match, out-of-buffers, overrun, CRC error and dribbling bits. The block steps at most one counter per frame. Exclusion rules that rank the errors choose that counter.

Software reads the counters through a small host port at any time. It can preset a counter only while the receive channel is disabled. Frame reception, CRC checking, address filtering and buffer handling live outside the block. Their results arrive only as the strobe flags.

Top module: `rx_err_stats`

## Requirements
- R1: After a synchronous reset all three counters read zero.
- R2: The CRC-error counter (select code 0) steps by one for a strobed frame that has the CRC error flag set, the address match flag set, and none of out-of-buffers, overrun or dribbling bits.
- R3: The alignment-error counter (select code 1) steps by one for a strobed frame that has dribbling bits and address match set, with neither out-of-buffers nor overrun set. The CRC flag does not matter.
- R4: The discard counter (select code 2) steps by one for every strobed frame that has out-of-buffers or overrun set. Address match and CRC flags do not matter.
- R5: A strobed frame steps at most one counter. A frame with dribbling bits never steps the CRC-error counter.
- R6: The counters wrap modulo 2^32: stepping 0xFFFFFFFF gives 0.
- R7: While rx_enable is low, a host write loads host_wdata into the counter that host_sel picks. Select code 3 addresses no counter.
- R8: While rx_enable is high, host writes change no counter.
- R9: If a host write and a step hit the same counter in the same cycle, the written value is stored.
- R10: Status flags have no effect in cycles where sts_valid is low.
- R11: host_rdata shows, one cycle after host_sel is presented, the value of the selected counter at that time. Select code 3 returns zero. Frames are counted whatever the state of rx_enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Receive channel enabled; blocks host writes when high |
| sts_valid | input | 1 | One-cycle end-of-frame status strobe |
| sts_addr_match | input | 1 | Frame was addressed to this station |
| sts_no_buf | input | 1 | Frame arrived with no receive buffer available |
| sts_overrun | input | 1 | Frame suffered a receive overrun |
| sts_crc_err | input | 1 | Frame CRC was bad |
| sts_dribble | input | 1 | Frame ended with dribbling bits |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Counter select: 0 CRC, 1 alignment, 2 discard, 3 none |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered read data of the selected counter |

## Verification
The case hardest to reach from the ports is the wrap of a 32-bit counter. Stepping there one frame at a time would take billions of strobes. The bench instead disables the channel, presets the alignment counter to 0xFFFFFFFF and then sends a single dribbling frame. The write-versus-step collision needs the same care. The bench raises a CRC-error strobe and a host write to the CRC counter on the same clock edge, with the channel disabled. Frames carrying several flags at once show the priority among the exclusion rules.

// File: rtl/rx_err_stats_pkg.sv
package rx_err_stats_pkg;
  localparam int NUM_CNT = 3;
  localparam int SEL_W   = 2;
  localparam int IDX_CRC   = 0;
  localparam int IDX_ALIGN = 1;
  localparam int IDX_DISC  = 2;

  typedef struct packed {
    logic addr_match;
    logic no_buf;
    logic overrun;
    logic crc_err;
    logic dribble;
  } rx_status_t;
endpackage

// File: rtl/rx_err_classify.sv
module rx_err_classify
  import rx_err_stats_pkg::*;
(
  input  logic               valid,
  input  rx_status_t         sts,
  output logic [NUM_CNT-1:0] hit
);
  logic dropped;
  logic counted_ok;

  always_comb begin
    dropped    = sts.no_buf | sts.overrun;
    counted_ok = sts.addr_match & ~dropped;
    hit        = '0;
    if (valid) begin
      hit[IDX_DISC]  = dropped;
      hit[IDX_ALIGN] = counted_ok & sts.dribble;
      hit[IDX_CRC]   = counted_ok & ~sts.dribble & sts.crc_err;
    end
  end
endmodule

// File: rtl/rx_err_counter.sv
module rx_err_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)
      value <= '0;
    else if (load)
      value <= load_val;
    else if (step)
      value <= value + CNT_W'(1);
  end
endmodule

// File: rtl/rx_err_stats.sv
module rx_err_stats
  import rx_err_stats_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_enable,
  input  logic             sts_valid,
  input  logic             sts_addr_match,
  input  logic             sts_no_buf,
  input  logic             sts_overrun,
  input  logic             sts_crc_err,
  input  logic             sts_dribble,
  input  logic             host_wr,
  input  logic [SEL_W-1:0] host_sel,
  input  logic [CNT_W-1:0] host_wdata,
  output logic [CNT_W-1:0] host_rdata
);
  rx_status_t                     sts;
  logic [NUM_CNT-1:0]             inc_hit;
  logic [NUM_CNT-1:0]             load_hit;
  logic [NUM_CNT-1:0][CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]               rd_mux;

  assign sts = '{addr_match: sts_addr_match, no_buf: sts_no_buf,
                 overrun: sts_overrun, crc_err: sts_crc_err,
                 dribble: sts_dribble};

  rx_err_classify u_cls (
    .valid (sts_valid),
    .sts   (sts),
    .hit   (inc_hit)
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    assign load_hit[i] = host_wr & ~rx_enable & (host_sel == SEL_W'(i));
    rx_err_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst      (rst),
      .step     (inc_hit[i]),
      .load     (load_hit[i]),
      .load_val (host_wdata),
      .value    (cnt_q[i])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (host_sel == SEL_W'(i)) rd_mux = cnt_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) host_rdata <= '0;
    else     host_rdata <= rd_mux;
  end
endmodule

// File: rtl/rx_err_stats_chk.sv
module rx_err_stats_chk
  import rx_err_stats_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          rx_enable,
  input logic                          sts_valid,
  input logic                          sts_dribble,
  input logic                          host_wr,
  input logic [SEL_W-1:0]              host_sel,
  input logic [CNT_W-1:0]              host_wdata,
  input logic [NUM_CNT-1:0]            inc_hit,
  input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_q
);
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));

  assert_single_step_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inc_hit));

  assert_dribble_no_crc_R5: assert property (@(posedge clk) disable iff (rst)
    (sts_valid && sts_dribble) |-> !inc_hit[IDX_CRC]);

  assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
    (!sts_valid && !host_wr) |=> $stable(cnt_q));

  assert_enabled_wr_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_enable && host_wr && !sts_valid) |=> $stable(cnt_q));

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_chk
    assert_preset_R7: assert property (@(posedge clk) disable iff (rst)
      (!rx_enable && host_wr && host_sel == SEL_W'(i))
        |=> (cnt_q[i] == $past(host_wdata)));

    assert_step_wrap_R6: assert property (@(posedge clk) disable iff (rst)
      (inc_hit[i] && !host_wr) |=> (cnt_q[i] == $past(cnt_q[i]) + CNT_W'(1)));

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
      (inc_hit[i] && !rx_enable && host_wr && host_sel == SEL_W'(i))
        |=> (cnt_q[i] == $past(host_wdata)));
  end
endmodule

bind rx_err_stats rx_err_stats_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_enable   (rx_enable),
  .sts_valid   (sts_valid),
  .sts_dribble (sts_dribble),
  .host_wr     (host_wr),
  .host_sel    (host_sel),
  .host_wdata  (host_wdata),
  .inc_hit     (inc_hit),
  .cnt_q       (cnt_q)
);

// File: tb/tb_rx_err_stats.sv
module tb_rx_err_stats;
  logic        clk = 0;
  logic        rst = 1;
  logic        rx_enable = 1;
  logic        sts_valid = 0;
  logic        sts_addr_match = 0, sts_no_buf = 0, sts_overrun = 0;
  logic        sts_crc_err = 0, sts_dribble = 0;
  logic        host_wr = 0;
  logic [1:0]  host_sel = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;
  logic [31:0] e_crc = 0, e_aln = 0, e_dis = 0;

  always #5 clk = ~clk;

  rx_err_stats dut (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .sts_valid(sts_valid),
    .sts_addr_match(sts_addr_match), .sts_no_buf(sts_no_buf),
    .sts_overrun(sts_overrun), .sts_crc_err(sts_crc_err),
    .sts_dribble(sts_dribble), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    host_sel = sel;
    @(posedge clk);
    @(negedge clk);
    v = host_rdata;
  endtask

  task automatic check_all(string req);
    logic [31:0] v;
    rd(2'd0, v); check({req, " crc"}, v, e_crc);
    rd(2'd1, v); check({req, " align"}, v, e_aln);
    rd(2'd2, v); check({req, " discard"}, v, e_dis);
  endtask

  task automatic frame(bit am, bit nb, bit ov, bit ce, bit dr);
    @(negedge clk);
    sts_valid = 1; sts_addr_match = am; sts_no_buf = nb;
    sts_overrun = ov; sts_crc_err = ce; sts_dribble = dr;
    @(negedge clk);
    sts_valid = 0; sts_addr_match = 0; sts_no_buf = 0;
    sts_overrun = 0; sts_crc_err = 0; sts_dribble = 0;
    if (nb || ov) e_dis++;
    else if (am && dr) e_aln++;
    else if (am && ce) e_crc++;
  endtask

  task automatic wr(logic [1:0] sel, logic [31:0] d);
    @(negedge clk);
    host_wr = 1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
    if (!rx_enable) begin
      if (sel == 0) e_crc = d;
      if (sel == 1) e_aln = d;
      if (sel == 2) e_dis = d;
    end
  endtask

  task automatic t_reset;
    logic [31:0] v;
    check_all("R1 reset");
    rd(2'd3, v); check("R11 sel3 zero", v, 32'h0);
  endtask

  task automatic t_crc;
    frame(1, 0, 0, 1, 0);   check_all("R2 addressed crc");
    frame(0, 0, 0, 1, 0);   check_all("R2 unaddressed crc");
    frame(1, 1, 0, 1, 0);   check_all("R5 crc with no_buf");
    frame(1, 0, 0, 1, 1);   check_all("R5 crc with dribble");
    frame(1, 0, 0, 0, 0);   check_all("R2 clean frame");
  endtask

  task automatic t_align;
    frame(1, 0, 0, 0, 1);   check_all("R3 dribble");
    frame(0, 0, 0, 0, 1);   check_all("R3 unaddressed dribble");
    frame(1, 0, 1, 1, 1);   check_all("R3 dribble with overrun");
  endtask

  task automatic t_discard;
    frame(1, 0, 1, 0, 0);   check_all("R4 overrun good crc");
    frame(0, 1, 0, 0, 0);   check_all("R4 unaddressed no_buf");
    frame(0, 1, 1, 1, 1);   check_all("R4 all flags");
  endtask

  task automatic t_ignore;
    @(negedge clk);
    sts_addr_match = 1; sts_crc_err = 1; sts_dribble = 1; sts_overrun = 1;
    repeat (4) @(negedge clk);
    sts_addr_match = 0; sts_crc_err = 0; sts_dribble = 0; sts_overrun = 0;
    check_all("R10 flags without strobe");
  endtask

  task automatic t_enabled_write;
    rx_enable = 1;
    wr(2'd0, 32'hDEAD0000);
    wr(2'd2, 32'h00BEEF00);
    check_all("R8 write while enabled");
  endtask

  task automatic t_preset_wrap;
    @(negedge clk); rx_enable = 0;
    wr(2'd0, 32'h00001234);
    wr(2'd2, 32'h7FFFFFFE);
    wr(2'd3, 32'h55555555);
    check_all("R7 preset");
    wr(2'd1, 32'hFFFFFFFF);
    frame(1, 0, 0, 0, 1);
    check_all("R6 wrap");
    check("R6 wrap value", e_aln, 32'h0);
    frame(1, 0, 1, 0, 0);
    check_all("R11 count while disabled");
  endtask

  task automatic t_write_wins;
    @(negedge clk);
    rx_enable = 0;
    sts_valid = 1; sts_addr_match = 1; sts_crc_err = 1;
    host_wr = 1; host_sel = 2'd0; host_wdata = 32'hA5A5A5A5;
    @(negedge clk);
    sts_valid = 0; sts_addr_match = 0; sts_crc_err = 0; host_wr = 0;
    e_crc = 32'hA5A5A5A5;
    check_all("R9 write wins");
    @(negedge clk); rx_enable = 1;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_crc();
    t_align();
    t_discard();
    t_ignore();
    t_enabled_write();
    t_preset_wrap();
    t_write_wins();
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule